// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block routes interrupts to a small group of processors, up to four. Each processor has a 64-bit mask over a shared raw device-request vector. A processor's device interrupt line is high while any bit of its masked request is set. Each processor also has a pending inter-processor interrupt (IPI) bit and a pending periodic timer bit. Each of these drives a level-sensitive line of its own. A periodic tick input posts the timer interrupt to every processor at once.

Software reaches the block through a single-beat 64-bit register port. The register index is the byte offset shifted right by six. A combined control register packs three per-processor fields: IPI request, IPI clear and timer clear. Separate registers also exist for each of those three actions. The block keeps sticky flags for two events: an IPI request to a processor that already has one pending, and an IPI clear for a processor that has none. Illegal accesses get an error response and change nothing.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Only accesses with `acc_size` equal to 3 (eight bytes) are legal. Any other size gives `rsp_err`=1 and `rsp_rdata`=0, and no state changes.
- R2: The register index is `acc_addr` shifted right by 6, so the low six address bits are ignored. The indices are: 0 control, 1 status, 2 raw request, 3 IPI clear, 4 timer clear, 5 IPI request, 8+c mask of processor c, 12+c masked request of processor c. Any other index gives an error with zero data and no state change.
- R3: Every access is answered exactly one cycle later with `rsp_valid` high for one cycle. A write returns zero data, and a successful read returns the register value from before that edge.
- R4: The mask registers reset to zero and read back what was written. Reading masked request c returns mask c ANDed with `raw_req`.
- R5: `dev_irq[c]` is high while mask c AND `raw_req` is nonzero. It follows a change of `raw_req` or a mask write one clock edge later.
- R6: The masked-request registers and the raw-request register are read-only. A write to any of them is an error and leaves every mask unchanged.
- R7: In a control write, bits 15:12 request IPIs, bits 11:8 clear IPIs and bits 7:4 clear timer interrupts, with bit 12+c, 8+c or 4+c belonging to processor c. A write with only bit 28 set is accepted and does nothing. A write with all of bits 15:4 and bit 28 clear is an error. A control read returns the IPI-pending vector at bits 11:8 and the timer-pending vector at bits 7:4, with all other bits zero.
- R8: An IPI request for processor c sets its pending bit and raises `ipi_irq[c]`. If that bit is already pending, the pending state is unchanged and status bit c is set. When one write both requests and clears the same processor, the clear wins and the bit ends clear.
- R9: An IPI clear for a processor with no pending IPI changes no pending state and sets status bit 4+c. A clear for a pending processor lowers `ipi_irq[c]`.
- R10: A `timer_tick` pulse sets the timer-pending bit and raises `tmr_irq` for every processor. A timer clear lowers only the selected bits and raises no flag. If a tick and a clear fall on the same edge, the tick wins and the bit stays set.
- R11: Writing the IPI clear, timer clear or IPI request register applies its low data bits as a per-processor mask, with bit c belonging to processor c. Reading the IPI clear register returns the IPI-pending vector, and reading the timer clear register returns the timer-pending vector.
- R12: Status resets to zero. Writing a 1 to a status bit clears that bit, and writing 0 leaves it alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 2 | log2 of access bytes; 3 is the only legal value |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the access |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| raw_req | input | REQ_W | Shared raw device-request vector |
| timer_tick | input | 1 | Periodic tick; posts the timer interrupt to all processors |
| dev_irq | output | NUM_CPU | Device interrupt line per processor |
| ipi_irq | output | NUM_CPU | Inter-processor interrupt line per processor |
| tmr_irq | output | NUM_CPU | Timer interrupt line per processor |

## Verification
Two functions can update the same timer-pending bit on one edge: the periodic tick, which sets every bit, and a timer-clear register write, which lowers chosen bits. The bench drives `timer_tick` high in the same cycle as a clear write aimed at a pending processor. It then checks that `tmr_irq` still shows all processors set, as the tick-wins rule requires. A second collision sits inside a single control write that both requests and clears one processor's IPI. There the bench expects the bit to end clear and no spurious-clear flag to appear in status.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

   localparam int MAX_CPU    = 4;
   localparam int WORD_W     = 64;
   localparam int CPU_SEL_W  = $clog2(MAX_CPU);
   localparam int IDX_SHIFT  = 6;

   localparam logic [1:0] SIZE_DWORD = 2'd3;

   localparam int IDX_CTRL      = 0;
   localparam int IDX_STATUS    = 1;
   localparam int IDX_RAW       = 2;
   localparam int IDX_IPI_CLR   = 3;
   localparam int IDX_TMR_CLR   = 4;
   localparam int IDX_IPI_SET   = 5;
   localparam int IDX_MASK_BASE = 8;
   localparam int IDX_MREQ_BASE = 12;

   localparam int CF_TMR_CLR_LSB = 4;
   localparam int CF_IPI_CLR_LSB = 8;
   localparam int CF_IPI_SET_LSB = 12;
   localparam int CF_IGNORE_BIT  = 28;

   typedef enum logic [3:0] {
      RK_NONE,
      RK_CTRL,
      RK_STATUS,
      RK_RAW,
      RK_IPI_CLR,
      RK_TMR_CLR,
      RK_IPI_SET,
      RK_MASK,
      RK_MREQ
   } reg_kind_e;

endpackage

// File: rtl/irq_mask_dec.sv
module irq_mask_dec
   import irq_mask_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12
) (
   input  logic                   acc_valid,
   input  logic                   acc_write,
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic [1:0]             acc_size,
   input  logic [WORD_W-1:0]      acc_wdata,
   output reg_kind_e              kind,
   output logic [CPU_SEL_W-1:0]   sel,
   output logic                   acc_err,
   output logic [NUM_CPU-1:0]     mask_we,
   output logic [NUM_CPU-1:0]     ipi_set,
   output logic [NUM_CPU-1:0]     ipi_clr,
   output logic [NUM_CPU-1:0]     tmr_clr,
   output logic [2*NUM_CPU-1:0]   sts_clr
);

   localparam int IDX_W = ADDR_W - IDX_SHIFT;
   localparam logic [IDX_W-1:0] I_CTRL    = IDX_W'(IDX_CTRL);
   localparam logic [IDX_W-1:0] I_STATUS  = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] I_RAW     = IDX_W'(IDX_RAW);
   localparam logic [IDX_W-1:0] I_IPI_CLR = IDX_W'(IDX_IPI_CLR);
   localparam logic [IDX_W-1:0] I_TMR_CLR = IDX_W'(IDX_TMR_CLR);
   localparam logic [IDX_W-1:0] I_IPI_SET = IDX_W'(IDX_IPI_SET);
   localparam logic [IDX_W-1:0] I_MASK_LO = IDX_W'(IDX_MASK_BASE);
   localparam logic [IDX_W-1:0] I_MASK_HI = IDX_W'(IDX_MASK_BASE + NUM_CPU);
   localparam logic [IDX_W-1:0] I_MREQ_LO = IDX_W'(IDX_MREQ_BASE);
   localparam logic [IDX_W-1:0] I_MREQ_HI = IDX_W'(IDX_MREQ_BASE + NUM_CPU);

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] off_mask;
   logic [IDX_W-1:0] off_mreq;
   logic             size_bad;
   logic             ctrl_empty;
   logic             ro_hit;
   logic             wr_ok;

   assign idx      = acc_addr[ADDR_W-1:IDX_SHIFT];
   assign off_mask = idx - I_MASK_LO;
   assign off_mreq = idx - I_MREQ_LO;

   always_comb begin
      kind = RK_NONE;
      sel  = '0;
      if (idx == I_CTRL)                          kind = RK_CTRL;
      else if (idx == I_STATUS)                   kind = RK_STATUS;
      else if (idx == I_RAW)                      kind = RK_RAW;
      else if (idx == I_IPI_CLR)                  kind = RK_IPI_CLR;
      else if (idx == I_TMR_CLR)                  kind = RK_TMR_CLR;
      else if (idx == I_IPI_SET)                  kind = RK_IPI_SET;
      else if (idx >= I_MASK_LO && idx < I_MASK_HI) begin
         kind = RK_MASK;
         sel  = off_mask[CPU_SEL_W-1:0];
      end else if (idx >= I_MREQ_LO && idx < I_MREQ_HI) begin
         kind = RK_MREQ;
         sel  = off_mreq[CPU_SEL_W-1:0];
      end
   end

   assign size_bad   = (acc_size != SIZE_DWORD);
   assign ctrl_empty = (acc_wdata[15:4] == '0) && !acc_wdata[CF_IGNORE_BIT];
   assign ro_hit     = (kind == RK_RAW) || (kind == RK_MREQ);
   assign acc_err    = size_bad || (kind == RK_NONE)
                       || (acc_write && ro_hit)
                       || (acc_write && (kind == RK_CTRL) && ctrl_empty);
   assign wr_ok      = acc_valid && acc_write && !acc_err;

   always_comb begin
      mask_we = '0;
      ipi_set = '0;
      ipi_clr = '0;
      tmr_clr = '0;
      sts_clr = '0;
      if (wr_ok) begin
         case (kind)
            RK_CTRL: begin
               ipi_set = acc_wdata[CF_IPI_SET_LSB +: NUM_CPU];
               ipi_clr = acc_wdata[CF_IPI_CLR_LSB +: NUM_CPU];
               tmr_clr = acc_wdata[CF_TMR_CLR_LSB +: NUM_CPU];
            end
            RK_IPI_SET: ipi_set = acc_wdata[NUM_CPU-1:0];
            RK_IPI_CLR: ipi_clr = acc_wdata[NUM_CPU-1:0];
            RK_TMR_CLR: tmr_clr = acc_wdata[NUM_CPU-1:0];
            RK_STATUS:  sts_clr = acc_wdata[2*NUM_CPU-1:0];
            RK_MASK: begin
               for (int c = 0; c < NUM_CPU; c++)
                  mask_we[c] = (sel == CPU_SEL_W'(c));
            end
            default: ;
         endcase
      end
   end

   logic unused_dec;
   assign unused_dec = ^{acc_addr[IDX_SHIFT-1:0], acc_wdata, off_mask, off_mreq};

endmodule

// File: rtl/irq_mask_dev.sv
module irq_mask_dev #(
   parameter int NUM_CPU = 4,
   parameter int REQ_W   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CPU-1:0] mask_we,
   input  logic [REQ_W-1:0]   wdata,
   input  logic [REQ_W-1:0]   raw_req,
   output logic [REQ_W-1:0]   mask_q [NUM_CPU],
   output logic [REQ_W-1:0]   mreq   [NUM_CPU],
   output logic [NUM_CPU-1:0] dev_irq
);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [REQ_W-1:0] mask_d;

      assign mask_d  = mask_we[c] ? wdata : mask_q[c];
      assign mreq[c] = mask_q[c] & raw_req;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[c]  <= '0;
            dev_irq[c] <= 1'b0;
         end else begin
            mask_q[c]  <= mask_d;
            dev_irq[c] <= |(mask_d & raw_req);
         end
      end

      AST_DEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_req == '0) |=> !dev_irq[c]); // R5

      AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_we[c] && wdata == '0) |=> !dev_irq[c]); // R5
   end

endmodule

// File: rtl/irq_mask_pend.sv
module irq_mask_pend #(
   parameter int NUM_CPU   = 4,
   parameter bit TICK_WINS = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CPU-1:0] set_req,
   input  logic [NUM_CPU-1:0] clr_req,
   input  logic               tick,
   output logic [NUM_CPU-1:0] pend,
   output logic [NUM_CPU-1:0] dup_evt,
   output logic [NUM_CPU-1:0] spur_evt
);

   logic [NUM_CPU-1:0] pend_d;
   logic [NUM_CPU-1:0] tick_v;

   assign tick_v   = {NUM_CPU{tick}};
   assign dup_evt  = set_req & pend;
   assign spur_evt = clr_req & ~pend & ~set_req;

   if (TICK_WINS) begin : g_tick_wins
      assign pend_d = (pend & ~clr_req) | set_req | tick_v;

      AST_TICK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> (&pend)); // R10
   end else begin : g_clear_last
      assign pend_d = (pend | set_req | tick_v) & ~clr_req;

      AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_req != '0) |=> ((pend & $past(clr_req)) == '0)); // R9

      AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         ((set_req & ~clr_req) != '0) |=>
            ((pend & $past(set_req & ~clr_req)) == $past(set_req & ~clr_req))); // R8
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_d;
   end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_mask_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12,
   parameter int REQ_W   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [1:0]         acc_size,
   input  logic [63:0]        acc_wdata,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [63:0]        rsp_rdata,
   input  logic [REQ_W-1:0]   raw_req,
   input  logic               timer_tick,
   output logic [NUM_CPU-1:0] dev_irq,
   output logic [NUM_CPU-1:0] ipi_irq,
   output logic [NUM_CPU-1:0] tmr_irq
);

   localparam int STS_W = 2 * NUM_CPU;

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("NUM_CPU must lie between 1 and %0d", MAX_CPU);
   end
   if (REQ_W < 1 || REQ_W > WORD_W) begin : g_bad_req
      $error("REQ_W must lie between 1 and %0d", WORD_W);
   end
   if (ADDR_W <= IDX_SHIFT + 3) begin : g_bad_addr
      $error("ADDR_W too narrow for the register index");
   end

   reg_kind_e            kind;
   logic [CPU_SEL_W-1:0] sel;
   logic                 dec_err;
   logic [NUM_CPU-1:0]   mask_we;
   logic [NUM_CPU-1:0]   ipi_set;
   logic [NUM_CPU-1:0]   ipi_clr;
   logic [NUM_CPU-1:0]   tmr_clr;
   logic [STS_W-1:0]     sts_clr;
   logic [REQ_W-1:0]     mask_q [NUM_CPU];
   logic [REQ_W-1:0]     mreq   [NUM_CPU];
   logic [NUM_CPU-1:0]   ipi_pend;
   logic [NUM_CPU-1:0]   tmr_pend;
   logic [NUM_CPU-1:0]   ipi_dup;
   logic [NUM_CPU-1:0]   ipi_spur;
   logic [NUM_CPU-1:0]   tmr_dup;
   logic [NUM_CPU-1:0]   tmr_spur;
   logic [STS_W-1:0]     status_q;
   logic [63:0]          rd_val;

   irq_mask_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .acc_wdata (acc_wdata),
      .kind      (kind),
      .sel       (sel),
      .acc_err   (dec_err),
      .mask_we   (mask_we),
      .ipi_set   (ipi_set),
      .ipi_clr   (ipi_clr),
      .tmr_clr   (tmr_clr),
      .sts_clr   (sts_clr)
   );

   irq_mask_dev #(.NUM_CPU(NUM_CPU), .REQ_W(REQ_W)) u_dev (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (mask_we),
      .wdata   (acc_wdata[REQ_W-1:0]),
      .raw_req (raw_req),
      .mask_q  (mask_q),
      .mreq    (mreq),
      .dev_irq (dev_irq)
   );

   irq_mask_pend #(.NUM_CPU(NUM_CPU), .TICK_WINS(1'b0)) u_ipi (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (ipi_set),
      .clr_req  (ipi_clr),
      .tick     (1'b0),
      .pend     (ipi_pend),
      .dup_evt  (ipi_dup),
      .spur_evt (ipi_spur)
   );

   irq_mask_pend #(.NUM_CPU(NUM_CPU), .TICK_WINS(1'b1)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  ('0),
      .clr_req  (tmr_clr),
      .tick     (timer_tick),
      .pend     (tmr_pend),
      .dup_evt  (tmr_dup),
      .spur_evt (tmr_spur)
   );

   logic unused_tmr;
   assign unused_tmr = ^{tmr_dup, tmr_spur};

   assign ipi_irq = ipi_pend;
   assign tmr_irq = tmr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~sts_clr) | {ipi_spur, ipi_dup};
   end

   always_comb begin
      rd_val = '0;
      case (kind)
         RK_CTRL: begin
            rd_val[CF_IPI_CLR_LSB +: NUM_CPU] = ipi_pend;
            rd_val[CF_TMR_CLR_LSB +: NUM_CPU] = tmr_pend;
         end
         RK_STATUS:  rd_val[STS_W-1:0]   = status_q;
         RK_RAW:     rd_val[REQ_W-1:0]   = raw_req;
         RK_IPI_CLR: rd_val[NUM_CPU-1:0] = ipi_pend;
         RK_TMR_CLR: rd_val[NUM_CPU-1:0] = tmr_pend;
         RK_MASK:    rd_val[REQ_W-1:0]   = mask_q[sel];
         RK_MREQ:    rd_val[REQ_W-1:0]   = mreq[sel];
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_err   <= acc_valid && dec_err;
         rsp_rdata <= (acc_valid && !acc_write && !dec_err) ? rd_val : '0;
      end
   end

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid); // R3

   AST_RSP_NO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid); // R3

   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R2

   AST_BAD_SIZE_NOCHG: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size != SIZE_DWORD) |=> ($stable(ipi_pend) && $stable(status_q))); // R1

   AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> (rsp_rdata == '0)); // R3

endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;

   localparam int NCPU   = 4;
   localparam int ADDR_W = 12;

   localparam int I_CTRL = 0, I_STS = 1, I_RAW = 2, I_IPICLR = 3, I_TMRCLR = 4,
                  I_IPISET = 5, I_MASK = 8, I_MREQ = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [1:0]        acc_size = 2'd3;
   logic [63:0]       acc_wdata = '0;
   logic              rsp_valid;
   logic              rsp_err;
   logic [63:0]       rsp_rdata;
   logic [63:0]       raw_req = '0;
   logic              timer_tick = 1'b0;
   logic [NCPU-1:0]   dev_irq;
   logic [NCPU-1:0]   ipi_irq;
   logic [NCPU-1:0]   tmr_irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   irq_mask_ctrl #(.NUM_CPU(NCPU), .ADDR_W(ADDR_W), .REQ_W(64)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .acc_wdata  (acc_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata),
      .raw_req    (raw_req),
      .timer_tick (timer_tick),
      .dev_irq    (dev_irq),
      .ipi_irq    (ipi_irq),
      .tmr_irq    (tmr_irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one access: driven after a falling edge, response sampled on the next falling edge
   task automatic access(input bit wr, input int idx, input logic [63:0] data,
                         input logic [1:0] size, input int low,
                         output logic ok_v, output logic err, output logic [63:0] rd);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = ADDR_W'((idx << 6) + low);
      acc_size  = size;
      acc_wdata = data;
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
      acc_wdata = '0;
      acc_size  = 2'd3;
      ok_v = rsp_valid;
      err  = rsp_err;
      rd   = rsp_rdata;
   endtask

   task automatic wr(input string req, input int idx, input logic [63:0] data, input logic exp_err);
      logic v, e; logic [63:0] d;
      access(1'b1, idx, data, 2'd3, 0, v, e, d);
      check({req, " write err"}, {63'd0, e}, {63'd0, exp_err});
   endtask

   task automatic rd_chk(input string req, input int idx, input logic [63:0] exp);
      logic v, e; logic [63:0] d;
      access(1'b0, idx, '0, 2'd3, 0, v, e, d);
      check({req, " read data"}, d, exp);
   endtask

   task automatic t_reset;
      check("R12 reset ipi", {60'd0, ipi_irq}, 64'd0);
      check("R10 reset tmr", {60'd0, tmr_irq}, 64'd0);
      check("R5 reset dev",  {60'd0, dev_irq}, 64'd0);
      rd_chk("R12 reset status", I_STS, 64'd0);
      rd_chk("R4 reset mask0", I_MASK, 64'd0);
   endtask

   task automatic t_timing;
      logic v, e; logic [63:0] d;
      access(1'b1, I_MASK + 3, 64'h77, 2'd3, 0, v, e, d);
      check("R3 rsp_valid after write", {63'd0, v}, 64'd1);
      check("R3 write returns zero", d, 64'd0);
      @(negedge clk);
      check("R3 rsp_valid single cycle", {63'd0, rsp_valid}, 64'd0);
      access(1'b0, I_MASK + 3, '0, 2'd3, 0, v, e, d);
      check("R3 read returns value", d, 64'h77);
      wr("R4 restore mask3", I_MASK + 3, 64'd0, 1'b0);
   endtask

   task automatic t_mask;
      wr("R4 mask0", I_MASK + 0, 64'h00F0, 1'b0);
      wr("R4 mask2", I_MASK + 2, 64'h8000_0000_0000_0001, 1'b0);
      check("R5 no raw no dev", {60'd0, dev_irq}, 64'd0);
      rd_chk("R4 mask0 readback", I_MASK, 64'h00F0);
      raw_req = 64'h10;
      @(negedge clk);
      check("R5 dev follows raw", {60'd0, dev_irq}, 64'b0001);
      rd_chk("R4 mreq0", I_MREQ + 0, 64'h10);
      rd_chk("R4 mreq2", I_MREQ + 2, 64'h0);
      raw_req = 64'h8000_0000_0000_0010;
      @(negedge clk);
      check("R5 dev two cpus", {60'd0, dev_irq}, 64'b0101);
      rd_chk("R4 mreq2 top bit", I_MREQ + 2, 64'h8000_0000_0000_0000);
      wr("R5 mask0 drop bit", I_MASK + 0, 64'h0F, 1'b0);
      check("R5 dev follows mask write", {60'd0, dev_irq}, 64'b0100);
      raw_req = 64'd0;
      @(negedge clk);
      check("R5 dev cleared", {60'd0, dev_irq}, 64'd0);
   endtask

   task automatic t_bad_access;
      logic v, e; logic [63:0] d;
      access(1'b1, I_MASK + 1, 64'hAA, 2'd2, 0, v, e, d);
      check("R1 short write err", {63'd0, e}, 64'd1);
      check("R1 short write data", d, 64'd0);
      rd_chk("R1 mask1 untouched", I_MASK + 1, 64'd0);
      access(1'b0, I_MASK + 0, '0, 2'd1, 0, v, e, d);
      check("R1 short read err", {63'd0, e}, 64'd1);
      check("R1 short read zero data", d, 64'd0);
      access(1'b0, 7, '0, 2'd3, 0, v, e, d);
      check("R2 unmapped err", {63'd0, e}, 64'd1);
      check("R2 unmapped data", d, 64'd0);
      access(1'b1, 20, 64'hFFFF, 2'd3, 0, v, e, d);
      check("R2 unmapped write err", {63'd0, e}, 64'd1);
      check("R2 unmapped write no ipi", {60'd0, ipi_irq}, 64'd0);
      access(1'b1, I_MASK + 1, 64'h55, 2'd3, 8, v, e, d);
      check("R2 low bits ignored err", {63'd0, e}, 64'd0);
      rd_chk("R2 low bits ignored", I_MASK + 1, 64'h55);
      wr("R2 restore mask1", I_MASK + 1, 64'd0, 1'b0);
   endtask

   task automatic t_readonly;
      wr("R6 write mreq1", I_MREQ + 1, 64'hFF, 1'b1);
      wr("R6 write raw", I_RAW, 64'hFF, 1'b1);
      rd_chk("R6 mask1 unchanged", I_MASK + 1, 64'd0);
      raw_req = 64'h1234;
      @(negedge clk);
      rd_chk("R6 raw readable", I_RAW, 64'h1234);
      raw_req = 64'd0;
      @(negedge clk);
   endtask

   task automatic t_ipi;
      wr("R7 ctrl request cpu0,1", I_CTRL, 64'h3000, 1'b0);
      check("R8 ipi raised", {60'd0, ipi_irq}, 64'h3);
      rd_chk("R7 ctrl read pending", I_CTRL, 64'h300);
      wr("R11 ipi request reg dup", I_IPISET, 64'h1, 1'b0);
      check("R8 dup keeps pending", {60'd0, ipi_irq}, 64'h3);
      rd_chk("R8 dup flag", I_STS, 64'h01);
      wr("R9 clear idle cpu2", I_CTRL, 64'h400, 1'b0);
      check("R9 idle clear no change", {60'd0, ipi_irq}, 64'h3);
      rd_chk("R9 spurious flag", I_STS, 64'h41);
      wr("R12 w1c bit0", I_STS, 64'h01, 1'b0);
      rd_chk("R12 w1c result", I_STS, 64'h40);
      wr("R8 request+clear cpu3", I_CTRL, 64'h8800, 1'b0);
      check("R8 clear wins", {60'd0, ipi_irq}, 64'h3);
      rd_chk("R8 no extra flag", I_STS, 64'h40);
      wr("R11 ipi clear reg", I_IPICLR, 64'h3, 1'b0);
      check("R9 pending cleared", {60'd0, ipi_irq}, 64'h0);
      rd_chk("R11 ipi clear reads pending", I_IPICLR, 64'h0);
      wr("R12 w1c all", I_STS, 64'hFF, 1'b0);
      rd_chk("R12 status empty", I_STS, 64'h0);
   endtask

   task automatic t_ctrl_misc;
      wr("R7 ignore bit accepted", I_CTRL, 64'h1000_0000, 1'b0);
      check("R7 ignore no ipi", {60'd0, ipi_irq}, 64'd0);
      check("R7 ignore no tmr", {60'd0, tmr_irq}, 64'd0);
      wr("R7 empty write err", I_CTRL, 64'h1, 1'b1);
      wr("R7 zero write err", I_CTRL, 64'h0, 1'b1);
      rd_chk("R7 status untouched", I_STS, 64'h0);
   endtask

   task automatic t_timer;
      logic v, e; logic [63:0] d;
      timer_tick = 1'b1;
      @(negedge clk);
      timer_tick = 1'b0;
      check("R10 tick sets all", {60'd0, tmr_irq}, 64'hF);
      rd_chk("R11 timer clear reads pending", I_TMRCLR, 64'hF);
      wr("R7 ctrl timer clear", I_CTRL, 64'h30, 1'b0);
      check("R10 partial clear", {60'd0, tmr_irq}, 64'hC);
      rd_chk("R7 ctrl read timer", I_CTRL, 64'hC0);
      // tick and clear on the same edge
      timer_tick = 1'b1;
      access(1'b1, I_TMRCLR, 64'h4, 2'd3, 0, v, e, d);
      timer_tick = 1'b0;
      check("R10 tick beats clear", {60'd0, tmr_irq}, 64'hF);
      wr("R11 timer clear reg", I_TMRCLR, 64'hF, 1'b0);
      check("R10 all cleared", {60'd0, tmr_irq}, 64'h0);
      wr("R10 clear idle timer", I_TMRCLR, 64'h1, 1'b0);
      rd_chk("R10 no timer flag", I_STS, 64'h0);
   endtask

   initial begin
      #(20 * 50000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timing();
      t_mask();
      t_bad_access();
      t_readonly();
      t_ipi();
      t_ctrl_misc();
      t_timer();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule